// File: doc/BRIEF.md
# Register-Mapped Real-Time Clock Core with Alarm and Interrupt Status

This block keeps wall-clock time as seconds, minutes, hours and a day count, and advances once for each one-second strobe it receives. A host reaches it through a plain word-addressed register bus with a combinational read path. The host sets the time, programs an alarm down to the day and the second, and services a set of interrupt sources through a status register and an enable register. One level interrupt line is raised while any enabled status bit is set.

The one-second strobe and nine faster periodic strobes (2 Hz up to 512 Hz, doubling each time) come from an external divider. Each periodic strobe sets its own status bit. The alarm source fires on the one-second strobe that moves the time onto the programmed alarm value. Status bits are cleared by writing ones. A control bit starts and stops the whole core.

Top module: `rtc_core`

## Requirements
- R1: After reset, every register reads zero and irq_o is low.
- R2: Word addresses on addr_i are: 0 hour/minute, 1 seconds, 2 alarm hour/minute, 3 alarm seconds, 4 control, 5 status, 6 enable, 8 day, 9 alarm day. Hour/minute words hold the hour in bits 12:8 and the minute in bits 5:0. Seconds are in bits 5:0. Day words use all 16 bits. Unused bits read zero.
- R3: While running, each tick_1hz_i pulse advances the seconds. Seconds and minutes roll from 59 to 0, and the hour rolls from 23 to 0. Leaving 23:59:59 increments the day, and the day wraps from 0xFFFF to 0.
- R4: Control bit 7 is the run bit. While it is 0, tick_1hz_i and per_i change neither the time nor the status register.
- R5: A host write to the hour/minute, seconds or day register in the same cycle as a tick_1hz_i pulse takes the written value, and none of the time fields advance in that cycle.
- R6: The alarm status bit is set by the tick that moves day, hour, minute and second all onto the alarm registers. A tick that matches only hour, minute and second does not set it.
- R7: Status and enable bit positions: bit 2 is the alarm, bit 4 is the one-second tick, and bit 7+k is per_i[k] (bit 7 is 2 Hz and bit 15 is 512 Hz). Bit 0 and the remaining bits always read 0.
- R8: Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged. Writing 0xFFFF clears every bit.
- R9: If a new event and a write-one-clear hit the same status bit in the same cycle, the bit stays set.
- R10: A status bit is set by its event whatever its enable bit says. irq_o is high exactly when some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register word address |
| we_i | input | 1 | Write strobe for the current address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| tick_1hz_i | input | 1 | One-cycle pulse once per second |
| per_i | input | 9 | One-cycle periodic pulses; bit k runs at 2^(k+1) Hz |
| irq_o | output | 1 | Interrupt, high while an enabled status bit is set |

## Verification
The range assertions assume the host writes only legal values: seconds and minutes up to 59, and hours up to 23. The counters keep whatever is written, so an illegal write would break these assertions without exposing any fault in the counting logic. Every time value the bench writes, whether from the vector table or from the directed tests, is legal. The checker also assumes strobes are single-cycle pulses. The bench drives each strobe high for exactly one clock, and changes inputs only on the falling edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_HM   = 4'd0,
    A_SEC  = 4'd1,
    A_AHM  = 4'd2,
    A_ASEC = 4'd3,
    A_CTRL = 4'd4,
    A_STAT = 4'd5,
    A_IEN  = 4'd6,
    A_DAY  = 4'd8,
    A_ADAY = 4'd9
  } reg_addr_e;

  localparam int B_ALM    = 2;
  localparam int B_1HZ    = 4;
  localparam int B_PER0   = 7;
  localparam int B_RUN    = 7;
  localparam int HR_LSB   = 8;
  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HR_W     = 5;
  localparam int SEC_LAST = 59;
  localparam int MIN_LAST = 59;
  localparam int HR_LAST  = 23;
endpackage

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt
  import rtc_pkg::*;
#(
  parameter int DAY_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              wr_hm_i,
  input  logic              wr_sec_i,
  input  logic              wr_day_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [MIN_W-1:0]  min_o,
  output logic [HR_W-1:0]   hr_o,
  output logic [DAY_W-1:0]  day_o,
  output logic [SEC_W-1:0]  nxt_sec_o,
  output logic [MIN_W-1:0]  nxt_min_o,
  output logic [HR_W-1:0]   nxt_hr_o,
  output logic [DAY_W-1:0]  nxt_day_o,
  output logic              adv_o
);
  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q;
  logic [HR_W-1:0]  hr_q;
  logic [DAY_W-1:0] day_q;
  logic sec_end, min_end, hr_end, wr_any;

  assign wr_any  = wr_hm_i | wr_sec_i | wr_day_i;
  assign adv_o   = run_i & tick_i & ~wr_any;
  assign sec_end = (sec_q == SEC_W'(SEC_LAST));
  assign min_end = (min_q == MIN_W'(MIN_LAST));
  assign hr_end  = (hr_q == HR_W'(HR_LAST));

  always_comb begin
    nxt_sec_o = sec_end ? '0 : sec_q + SEC_W'(1);
    nxt_min_o = min_q;
    nxt_hr_o  = hr_q;
    nxt_day_o = day_q;
    if (sec_end) begin
      nxt_min_o = min_end ? '0 : min_q + MIN_W'(1);
      if (min_end) begin
        nxt_hr_o = hr_end ? '0 : hr_q + HR_W'(1);
        if (hr_end) nxt_day_o = day_q + DAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
      day_q <= '0;
    end else if (adv_o) begin
      sec_q <= nxt_sec_o;
      min_q <= nxt_min_o;
      hr_q  <= nxt_hr_o;
      day_q <= nxt_day_o;
    end else begin
      // host write wins over a coincident tick
      if (wr_sec_i) sec_q <= wdata_i[SEC_W-1:0];
      if (wr_hm_i) begin
        min_q <= wdata_i[MIN_W-1:0];
        hr_q  <= wdata_i[HR_LSB +: HR_W];
      end
      if (wr_day_i) day_q <= wdata_i[DAY_W-1:0];
    end
  end

  assign sec_o = sec_q;
  assign min_o = min_q;
  assign hr_o  = hr_q;
  assign day_o = day_q;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_pkg::*;
#(
  parameter int DAY_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ahm_i,
  input  logic              wr_asec_i,
  input  logic              wr_aday_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              adv_i,
  input  logic [SEC_W-1:0]  nxt_sec_i,
  input  logic [MIN_W-1:0]  nxt_min_i,
  input  logic [HR_W-1:0]   nxt_hr_i,
  input  logic [DAY_W-1:0]  nxt_day_i,
  output logic [SEC_W-1:0]  asec_o,
  output logic [MIN_W-1:0]  amin_o,
  output logic [HR_W-1:0]   ahr_o,
  output logic [DAY_W-1:0]  aday_o,
  output logic              hit_o
);
  logic [SEC_W-1:0] asec_q;
  logic [MIN_W-1:0] amin_q;
  logic [HR_W-1:0]  ahr_q;
  logic [DAY_W-1:0] aday_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asec_q <= '0;
      amin_q <= '0;
      ahr_q  <= '0;
      aday_q <= '0;
    end else begin
      if (wr_asec_i) asec_q <= wdata_i[SEC_W-1:0];
      if (wr_ahm_i) begin
        amin_q <= wdata_i[MIN_W-1:0];
        ahr_q  <= wdata_i[HR_LSB +: HR_W];
      end
      if (wr_aday_i) aday_q <= wdata_i[DAY_W-1:0];
    end
  end

  // compare against the time this tick lands on
  assign hit_o = adv_i && (nxt_sec_i == asec_q) && (nxt_min_i == amin_q)
              && (nxt_hr_i == ahr_q) && (nxt_day_i == aday_q);

  assign asec_o = asec_q;
  assign amin_o = amin_q;
  assign ahr_o  = ahr_q;
  assign aday_o = aday_q;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_pkg::*;
#(
  parameter int NPER = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [NPER-1:0]   per_i,
  input  logic              alarm_i,
  input  logic              wr_stat_i,
  input  logic              wr_ien_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] ien_o,
  output logic              irq_o
);
  localparam int TOP_BIT = B_PER0 + NPER - 1;

  logic [DATA_W-1:0] ev, mask, clr, stat_q, ien_q;

  always_comb begin
    mask = '0;
    mask[B_ALM] = 1'b1;
    mask[B_1HZ] = 1'b1;
    for (int k = B_PER0; k <= TOP_BIT; k++) mask[k] = 1'b1;
  end

  always_comb begin
    ev = '0;
    ev[B_ALM] = alarm_i;
    ev[B_1HZ] = run_i & tick_i;
  end

  logic [NPER-1:0] per_ev;
  for (genvar k = 0; k < NPER; k++) begin : g_per
    assign per_ev[k] = run_i & per_i[k];
  end

  logic [DATA_W-1:0] ev_all;
  always_comb begin
    ev_all = ev;
    ev_all[B_PER0 +: NPER] = per_ev;
  end

  assign clr = wr_stat_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ien_q  <= '0;
    end else begin
      stat_q <= ((stat_q & ~clr) | ev_all) & mask;
      if (wr_ien_i) ien_q <= wdata_i & mask;
    end
  end

  assign stat_o = stat_q;
  assign ien_o  = ien_q;
  assign irq_o  = |(stat_q & ien_q);
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int DAY_W = 16,
  parameter int NPER  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_1hz_i,
  input  logic [NPER-1:0]   per_i,
  output logic              irq_o
);
  logic run_q;
  logic [SEC_W-1:0] t_sec, n_sec, a_sec;
  logic [MIN_W-1:0] t_min, n_min, a_min;
  logic [HR_W-1:0]  t_hr, n_hr, a_hr;
  logic [DAY_W-1:0] t_day, n_day, a_day;
  logic adv, hit;
  logic [DATA_W-1:0] stat, ien;

  logic wr_hm, wr_sec, wr_day, wr_ahm, wr_asec, wr_aday, wr_ctrl, wr_stat, wr_ien;
  assign wr_hm   = we_i && (addr_i == A_HM);
  assign wr_sec  = we_i && (addr_i == A_SEC);
  assign wr_day  = we_i && (addr_i == A_DAY);
  assign wr_ahm  = we_i && (addr_i == A_AHM);
  assign wr_asec = we_i && (addr_i == A_ASEC);
  assign wr_aday = we_i && (addr_i == A_ADAY);
  assign wr_ctrl = we_i && (addr_i == A_CTRL);
  assign wr_stat = we_i && (addr_i == A_STAT);
  assign wr_ien  = we_i && (addr_i == A_IEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (wr_ctrl) run_q <= wdata_i[B_RUN];
  end

  rtc_time_cnt #(.DAY_W(DAY_W)) u_time (
    .clk_i, .rst_ni,
    .run_i(run_q), .tick_i(tick_1hz_i),
    .wr_hm_i(wr_hm), .wr_sec_i(wr_sec), .wr_day_i(wr_day), .wdata_i,
    .sec_o(t_sec), .min_o(t_min), .hr_o(t_hr), .day_o(t_day),
    .nxt_sec_o(n_sec), .nxt_min_o(n_min), .nxt_hr_o(n_hr), .nxt_day_o(n_day),
    .adv_o(adv)
  );

  rtc_alarm_cmp #(.DAY_W(DAY_W)) u_alarm (
    .clk_i, .rst_ni,
    .wr_ahm_i(wr_ahm), .wr_asec_i(wr_asec), .wr_aday_i(wr_aday), .wdata_i,
    .adv_i(adv), .nxt_sec_i(n_sec), .nxt_min_i(n_min), .nxt_hr_i(n_hr), .nxt_day_i(n_day),
    .asec_o(a_sec), .amin_o(a_min), .ahr_o(a_hr), .aday_o(a_day),
    .hit_o(hit)
  );

  rtc_irq_ctrl #(.NPER(NPER)) u_irq (
    .clk_i, .rst_ni,
    .run_i(run_q), .tick_i(tick_1hz_i), .per_i, .alarm_i(hit),
    .wr_stat_i(wr_stat), .wr_ien_i(wr_ien), .wdata_i,
    .stat_o(stat), .ien_o(ien), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_HM:    begin rdata_o[HR_LSB +: HR_W] = t_hr; rdata_o[MIN_W-1:0] = t_min; end
      A_SEC:   rdata_o[SEC_W-1:0] = t_sec;
      A_AHM:   begin rdata_o[HR_LSB +: HR_W] = a_hr; rdata_o[MIN_W-1:0] = a_min; end
      A_ASEC:  rdata_o[SEC_W-1:0] = a_sec;
      A_CTRL:  rdata_o[B_RUN] = run_q;
      A_STAT:  rdata_o = stat;
      A_IEN:   rdata_o = ien;
      A_DAY:   rdata_o[DAY_W-1:0] = t_day;
      A_ADAY:  rdata_o[DAY_W-1:0] = a_day;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
  import rtc_pkg::*;
#(
  parameter int DAY_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              tick_1hz_i,
  input logic              irq_o,
  input logic              run,
  input logic [DATA_W-1:0] stat,
  input logic [DATA_W-1:0] ien,
  input logic [SEC_W-1:0]  sec,
  input logic [MIN_W-1:0]  mn,
  input logic [HR_W-1:0]   hr,
  input logic [DAY_W-1:0]  day
);
  logic wr_time;
  assign wr_time = we_i && (addr_i == A_HM || addr_i == A_SEC || addr_i == A_DAY);

  // R3
  sec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec <= SEC_W'(SEC_LAST)) && (mn <= MIN_W'(MIN_LAST)) && (hr <= HR_W'(HR_LAST)));

  // R4
  halt_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_time) |=> $stable({day, hr, mn, sec}));

  // R8
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_STAT && wdata_i[B_1HZ] && !(run && tick_1hz_i)) |=> !stat[B_1HZ]);

  // R9
  event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tick_1hz_i) |=> stat[B_1HZ]);

  // R10
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|ien));

  // R7
  sw_bit_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat[0] && !ien[0]);
endmodule

bind rtc_core rtc_core_chk #(.DAY_W(DAY_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
  .tick_1hz_i(tick_1hz_i), .irq_o(irq_o), .run(run_q), .stat(stat), .ien(ien),
  .sec(t_sec), .mn(t_min), .hr(t_hr), .day(t_day)
);

// File: tb/tb_rtc_core.sv
module tb_rtc_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        tick = 1'b0;
  logic [8:0]  per = '0;
  logic        irq;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_core dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .tick_1hz_i(tick), .per_i(per), .irq_o(irq)
  );

  // {day, hr, min, sec, ticks, exp day, exp hr, exp min, exp sec} (R3)
  localparam int NV = 7;
  localparam logic [95:0] VEC [NV] = '{
    {16'd0,     8'd0,  8'd0,  8'd0,  16'd1, 16'd0, 8'd0,  8'd0,  8'd1},
    {16'd0,     8'd0,  8'd0,  8'd59, 16'd1, 16'd0, 8'd0,  8'd1,  8'd0},
    {16'd0,     8'd0,  8'd59, 8'd59, 16'd1, 16'd0, 8'd1,  8'd0,  8'd0},
    {16'd3,     8'd23, 8'd59, 8'd59, 16'd1, 16'd4, 8'd0,  8'd0,  8'd0},
    {16'd0,     8'd12, 8'd34, 8'd56, 16'd5, 16'd0, 8'd12, 8'd35, 8'd1},
    {16'hFFFF,  8'd23, 8'd59, 8'd59, 16'd1, 16'd0, 8'd0,  8'd0,  8'd0},
    {16'd0,     8'd23, 8'd59, 8'd58, 16'd3, 16'd1, 8'd0,  8'd0,  8'd1}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulse_per(logic [8:0] p);
    @(negedge clk); per = p;
    @(negedge clk); per = '0;
  endtask

  task automatic set_time(logic [15:0] d, logic [7:0] h, logic [7:0] m, logic [7:0] s);
    wr(4'd8, d); wr(4'd1, {8'd0, s}); wr(4'd0, {h, m});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], v); check("R1 reset read", v, 16'h0000);
    end
    check("R1 irq after reset", {15'd0, irq}, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk);

    // R4 halted core ignores strobes
    set_time(16'd2, 8'd5, 8'd6, 8'd7);
    pulse_tick(); pulse_per(9'h1FF);
    rd(4'd1, v); check("R4 halted seconds", v, 16'd7);
    rd(4'd0, v); check("R4 halted hour/minute", v, 16'h0506);
    rd(4'd5, v); check("R4 halted status", v, 16'h0000);

    wr(4'd4, 16'h0080);
    rd(4'd4, v); check("R2 control run bit", v, 16'h0080);

    // R3 vector table
    for (int i = 0; i < NV; i++) begin
      logic [95:0] e;
      e = VEC[i];
      set_time(e[95:80], e[79:72], e[71:64], e[63:56]);
      for (int t = 0; t < int'(e[55:40]); t++) pulse_tick();
      rd(4'd8, v); check("R3 day", v, e[39:24]);
      rd(4'd0, v); check("R3 hour/minute", v, e[23:8]);
      rd(4'd1, v); check("R3 seconds", v, {8'd0, e[7:0]});
    end

    // R2 alarm register layout
    wr(4'd2, 16'hFF7F); rd(4'd2, v); check("R2 alarm hm mask", v, 16'h1F3F);
    wr(4'd3, 16'hFFFF); rd(4'd3, v); check("R2 alarm sec mask", v, 16'h003F);

    // R5 write beats tick
    set_time(16'd0, 8'd1, 8'd2, 8'd10);
    @(negedge clk); tick = 1'b1; addr = 4'd1; wdata = 16'd40; we = 1'b1;
    @(negedge clk); tick = 1'b0; we = 1'b0;
    rd(4'd1, v); check("R5 written seconds kept", v, 16'd40);
    rd(4'd0, v); check("R5 hour/minute unchanged", v, 16'h0102);

    // R6 alarm on full match
    wr(4'd5, 16'hFFFF);
    wr(4'd9, 16'd1); wr(4'd2, 16'h0A14); wr(4'd3, 16'd30);
    set_time(16'd1, 8'd10, 8'd20, 8'd29);
    pulse_tick();
    rd(4'd5, v); check("R6 alarm and 1Hz set", v, 16'h0014);
    wr(4'd5, 16'hFFFF);
    set_time(16'd0, 8'd10, 8'd20, 8'd29);
    pulse_tick();
    rd(4'd5, v); check("R6 day mismatch no alarm", v, 16'h0010);

    // R8 write zero keeps, write one clears
    wr(4'd5, 16'h0000); rd(4'd5, v); check("R8 zero write no effect", v, 16'h0010);
    wr(4'd5, 16'h0010); rd(4'd5, v); check("R8 one write clears", v, 16'h0000);

    // R7 periodic positions
    pulse_per(9'h001); rd(4'd5, v); check("R7 2Hz bit7", v, 16'h0080);
    pulse_per(9'h100); rd(4'd5, v); check("R7 512Hz bit15", v, 16'h8080);
    pulse_per(9'h1FF); rd(4'd5, v); check("R7 all periodic", v, 16'hFF80);
    wr(4'd6, 16'hFFFF); rd(4'd6, v); check("R7 enable mask", v, 16'hFF94);
    wr(4'd6, 16'h0000);
    wr(4'd5, 16'hFFFF); rd(4'd5, v); check("R8 all ones clears", v, 16'h0000);

    // R9 event beats clear
    pulse_tick();
    @(negedge clk); tick = 1'b1; addr = 4'd5; wdata = 16'h0010; we = 1'b1;
    @(negedge clk); tick = 1'b0; we = 1'b0;
    rd(4'd5, v); check("R9 event wins", v, 16'h0010);

    // R10 interrupt gating
    check("R10 irq low, not enabled", {15'd0, irq}, 16'h0000);
    wr(4'd6, 16'h0010); #1;
    check("R10 irq high, enabled", {15'd0, irq}, 16'h0001);
    wr(4'd6, 16'h0004); #1;
    check("R10 irq low, other enable", {15'd0, irq}, 16'h0000);
    wr(4'd6, 16'h0010); wr(4'd5, 16'h0010); #1;
    check("R10 irq drops after clear", {15'd0, irq}, 16'h0000);

    finish_run();
  end
endmodule